// File: doc/BRIEF.md
# Physical Address Cacheability Checker

This block sits after address translation. It receives a physical address, a flag that marks instruction fetches, a flag that marks addresses produced by the direct-mapped kernel superpage, and a request valid. One cycle later it returns the final physical address, an uncacheable attribute, a strict-ordering attribute, and a fault code.

The block applies three checks in a fixed order. First, superpage addresses are normalised: they are masked to the implemented width and sign-extended from bit 40 into bits 43:40. Second, any address bit above the implemented range raises a machine-check fault. Third, bit 43 selects uncached space. Within that space, a configurable compare on the bits just below bit 43 marks an internal-register window, which is not implemented and faults. Every other uncached address is marked uncacheable and strictly ordered, and its region-select bits 42:35 are cleared. An instruction fetch that lands in uncached space is refused, because reading a device register can destroy data that clears on read.

Fault codes: 2'b00 none, 2'b01 machine check, 2'b10 unimplemented space.

Top module: `pacc_check`

## Requirements
- R1: outValid is low in reset and, one cycle after each rising clock edge, equals the inValid that was sampled at that edge. All result outputs appear in the same cycle as outValid.
- R2: A non-superpage address with any bit at or above bit 44 set gives outFault 2'b01, outUncache 0 and outStrict 0. outAddr then equals the input address.
- R3: The machine-check test is applied before the uncached-space test. An out-of-range address that also has bit 43 set therefore gives 2'b01 and is neither stripped nor marked uncacheable.
- R4: An in-range address with bit 43 set and bits 42:40 equal to 3'b110 gives outFault 2'b10, outUncache 0 and outStrict 0. outAddr is left unchanged.
- R5: Any other in-range data access with bit 43 set gives outUncache 1, outStrict 1 and outFault 2'b00. outAddr equals the input with bits 42:35 cleared.
- R6: An instruction fetch that meets the R5 condition gives outFault 2'b10. outUncache and outStrict are still 1, and the address is still stripped.
- R7: An in-range address with bit 43 clear passes through unchanged, with both attributes 0 and outFault 2'b00, for fetches and for data accesses alike.
- R8: When inSuper is 1, the address is first masked to bits 43:0. If bit 40 is then set, bits 43:40 are forced to 1 and the result continues through R5 or R6. Otherwise the address is cut to bits 39:0. A superpage address never gives a machine check.

Both R3 and R4 are reached only after the machine-check test has passed or failed as stated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid |
| inAddr | input | 64 | Physical address from translation |
| inFetch | input | 1 | Request is an instruction fetch |
| inSuper | input | 1 | Address came from the superpage mapping |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outAddr | output | 64 | Final physical address |
| outUncache | output | 1 | Request is uncacheable |
| outStrict | output | 1 | Request must be strictly ordered |
| outFault | output | 2 | 00 none, 01 machine check, 10 unimplemented |

## Verification
The assertions assume that inFetch and inSuper are meaningful only in the cycle where inValid is high. They also assume that inSuper comes with an address whose upper bits may hold anything, because the block masks those bits itself. The stimulus holds every input steady between falling edges. It drives inSuper and inFetch low during reset. It sweeps all sixteen combinations of bits 43:40, with and without a stray high bit, across both flags, and it interleaves idle cycles so the valid path is also exercised with inValid low.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_MCHK  = 2'b01,
    FLT_UNIMP = 2'b10
  } faultE;

  typedef struct packed {
    logic  capture;
    logic  strip;
    logic  markUnc;
    faultE fault;
  } strobeS;

endpackage

// File: rtl/pacc_datapath.sv
module pacc_datapath
  import pacc_pkg::*;
#(
  parameter int PA_W        = 64,
  parameter int IMPL_W      = 44,
  parameter int SPX_BIT     = 40,
  parameter int STRIP_HI    = 42,
  parameter int STRIP_LO    = 35,
  parameter int REG_SEL_LSB = 40,
  parameter int REG_SEL_VAL = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PA_W-1:0] inAddr,
  input  logic            inSuper,
  input  strobeS          strobes,
  output logic            outOfRange,
  output logic            uncSel,
  output logic            regSpace,
  output logic [PA_W-1:0] outAddr
);

  localparam int UNC_BIT = IMPL_W - 1;
  localparam int REG_W   = UNC_BIT - REG_SEL_LSB;
  localparam int STRIP_W = STRIP_HI - STRIP_LO + 1;
  localparam logic [REG_W-1:0] REG_KEY = REG_W'(REG_SEL_VAL);

  localparam logic [PA_W-1:0] IMPL_MASK =
    {{(PA_W-IMPL_W){1'b0}}, {IMPL_W{1'b1}}};
  localparam logic [PA_W-1:0] SPX_FILL =
    {{(PA_W-IMPL_W){1'b0}}, {(IMPL_W-SPX_BIT){1'b1}}, {SPX_BIT{1'b0}}};
  localparam logic [PA_W-1:0] LOW_MASK =
    {{(PA_W-SPX_BIT){1'b0}}, {SPX_BIT{1'b1}}};
  localparam logic [PA_W-1:0] STRIP_KEEP =
    ~{{(PA_W-STRIP_HI-1){1'b0}}, {STRIP_W{1'b1}}, {STRIP_LO{1'b0}}};

  logic [PA_W-1:0] maskedAddr;
  logic [PA_W-1:0] superAddr;
  logic [PA_W-1:0] normAddr;
  logic [PA_W-1:0] finalAddr;

  // Superpage normalisation: mask, then sign-extend from the extension bit
  always_comb begin
    maskedAddr = inAddr & IMPL_MASK;
    if (maskedAddr[SPX_BIT]) begin
      superAddr = maskedAddr | SPX_FILL;
    end else begin
      superAddr = maskedAddr & LOW_MASK;
    end
    normAddr = inSuper ? superAddr : inAddr;
  end

  // Address classification handed to the control
  always_comb begin
    outOfRange = |(normAddr & ~IMPL_MASK);
    uncSel     = normAddr[UNC_BIT];
    regSpace   = (normAddr[UNC_BIT-1:REG_SEL_LSB] == REG_KEY);
  end

  always_comb begin
    finalAddr = strobes.strip ? (normAddr & STRIP_KEEP) : normAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr <= '0;
    end else if (strobes.capture) begin
      outAddr <= finalAddr;
    end
  end

endmodule

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
  import pacc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inFetch,
  input  logic       outOfRange,
  input  logic       uncSel,
  input  logic       regSpace,
  output strobeS     strobes,
  output logic       outValid,
  output logic       outUncache,
  output logic       outStrict,
  output logic [1:0] outFault
);

  faultE faultQ;

  // Ordered decision: range check first, then cacheability, then fetch gate
  always_comb begin
    strobes         = '0;
    strobes.capture = inValid;
    strobes.fault   = FLT_NONE;
    if (outOfRange) begin
      strobes.fault = FLT_MCHK;
    end else if (uncSel) begin
      if (regSpace) begin
        strobes.fault = FLT_UNIMP;
      end else begin
        strobes.strip   = 1'b1;
        strobes.markUnc = 1'b1;
        if (inFetch) begin
          strobes.fault = FLT_UNIMP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outUncache <= 1'b0;
      outStrict  <= 1'b0;
      faultQ     <= FLT_NONE;
    end else begin
      outValid   <= inValid;
      outUncache <= inValid & strobes.markUnc;
      outStrict  <= inValid & strobes.markUnc;
      faultQ     <= inValid ? strobes.fault : FLT_NONE;
    end
  end

  assign outFault = faultQ;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid) else $error("valid not forwarded"); // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid) else $error("spurious valid"); // R1
  AST_MCHK_NO_ATTR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultQ == FLT_MCHK) |-> (!outUncache && !outStrict)) else $error("attr on mchk"); // R3
  AST_FETCH_UNC_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFetch) |=> (!outUncache || faultQ == FLT_UNIMP)) else $error("uncached fetch allowed"); // R6

endmodule

// File: rtl/pacc_check.sv
module pacc_check
  import pacc_pkg::*;
#(
  parameter int PA_W        = 64,
  parameter int IMPL_W      = 44,
  parameter int SPX_BIT     = 40,
  parameter int STRIP_HI    = 42,
  parameter int STRIP_LO    = 35,
  parameter int REG_SEL_LSB = 40,
  parameter int REG_SEL_VAL = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [PA_W-1:0] inAddr,
  input  logic            inFetch,
  input  logic            inSuper,
  output logic            outValid,
  output logic [PA_W-1:0] outAddr,
  output logic            outUncache,
  output logic            outStrict,
  output logic [1:0]      outFault
);

  strobeS strobes;
  logic   outOfRange;
  logic   uncSel;
  logic   regSpace;

  pacc_datapath #(
    .PA_W(PA_W), .IMPL_W(IMPL_W), .SPX_BIT(SPX_BIT),
    .STRIP_HI(STRIP_HI), .STRIP_LO(STRIP_LO),
    .REG_SEL_LSB(REG_SEL_LSB), .REG_SEL_VAL(REG_SEL_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inAddr(inAddr), .inSuper(inSuper),
    .strobes(strobes), .outOfRange(outOfRange), .uncSel(uncSel),
    .regSpace(regSpace), .outAddr(outAddr)
  );

  pacc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFetch(inFetch),
    .outOfRange(outOfRange), .uncSel(uncSel), .regSpace(regSpace),
    .strobes(strobes), .outValid(outValid), .outUncache(outUncache),
    .outStrict(outStrict), .outFault(outFault)
  );

  AST_UNC_STRIPPED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUncache) |-> (outAddr[STRIP_HI:STRIP_LO] == '0)) else $error("not stripped"); // R5
  AST_CLEAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFault == FLT_NONE) |-> (outAddr[PA_W-1:IMPL_W] == '0)) else $error("high bits leak"); // R2
  AST_SUPER_NO_MCHK: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSuper) |=> (outFault != FLT_MCHK)) else $error("superpage mchk"); // R8

endmodule

// File: tb/pacc_check_tb.sv
`timescale 1ns/1ps
module pacc_check_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] inAddr;
  logic        inFetch;
  logic        inSuper;
  logic        outValid;
  logic [63:0] outAddr;
  logic        outUncache;
  logic        outStrict;
  logic [1:0]  outFault;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pacc_check u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .inFetch(inFetch), .inSuper(inSuper), .outValid(outValid),
    .outAddr(outAddr), .outUncache(outUncache), .outStrict(outStrict),
    .outFault(outFault)
  );

  task automatic check(input string req, input logic [63:0] gotA, input logic [63:0] expA,
                       input logic [3:0] gotF, input logic [3:0] expF);
    checks++;
    if (gotA !== expA || gotF !== expF) begin
      errors++;
      $display("FAIL %s addr=%h flags=%b expected addr=%h flags=%b", req, gotA, gotF, expA, expF);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inAddr = '0; inFetch = 1'b0; inSuper = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", outAddr, 64'd0, {outValid, outUncache, outStrict, 1'b0}, 4'b0000);
    check("R1", 64'd0, 64'd0, {2'b00, outFault}, 4'b0000);
    rstN = 1'b1;
    for (int i = 0; i < 512; i++) begin
      logic [63:0] a, lo, expA;
      logic        f, sp, vld, expU;
      logic [1:0]  expF;
      string       tag;
      lo  = (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(i) << 11);
      a   = lo & 64'h0000_00FF_FFFF_FFFF;
      a[43:40] = 4'(i);
      if (i[4]) a[44 + (i % 20)] = 1'b1;
      f   = i[5];
      sp  = i[6];
      vld = !i[7] || i[8];
      inAddr = a; inFetch = f; inSuper = sp; inValid = vld;
      // expected result from the requirements
      expA = a; expU = 1'b0; expF = 2'b00;
      if (sp) begin
        expA = a & 64'h0000_0FFF_FFFF_FFFF;
        if (expA[40]) expA = expA | 64'h0000_0F00_0000_0000;
        else          expA = expA & 64'h0000_00FF_FFFF_FFFF;
      end
      if (expA[63:44] != 0) begin
        expF = 2'b01;
        tag = expA[43] ? "R3" : "R2";
      end else if (expA[43]) begin
        if (expA[42:40] == 3'b110) begin
          expF = 2'b10; tag = "R4";
        end else begin
          expU = 1'b1;
          expA[42:35] = 8'h00;
          if (f) begin expF = 2'b10; tag = "R6"; end
          else tag = "R5";
        end
      end else begin
        tag = "R7";
      end
      if (sp) tag = "R8";
      @(negedge clk);
      if (vld) begin
        check(tag, outAddr, expA, {outValid, outUncache, outStrict, 1'b0}, {1'b1, expU, expU, 1'b0});
        check(tag, 64'(outFault), 64'(expF), 4'd0, 4'd0);
      end else begin
        check("R1", 64'(outFault), 64'd0, {outValid, outUncache, outStrict, 1'b0}, 4'b0000);
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R1", 64'd0, 64'd0, {outValid, 3'b000}, 4'b0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule